// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block sits between a group of peripheral interrupt lines and a processor core. Each source has its own two-bit priority level, set through a small synchronous register port. A one-cycle pulse on a source's request line makes that source pending. The core supplies its current two-bit status mask, and only pending sources whose level is at or above the mask are eligible. The highest eligible level wins. When several eligible sources share that level, the one with the lowest vector number wins. The block then presents a request to the core, together with the vector number and a handler address.

For an ordinary interrupt, the handler address is the programmed vector base with the winner's vector number appended below it. Two fast-interrupt slots each hold a match vector, an enable bit and a full handler address. When the winner is at level 2 and its vector matches an enabled slot, the slot's address is presented in place of the base-plus-vector address, and a fast flag is raised. The request and its address stay frozen until the core acknowledges. The acknowledge retires the served source's pending flag.

Nesting works through the mask. After taking an interrupt, the core raises the mask above the level it is serving. Only sources of a higher level then get through, and lower ones wait in their pending flags until the mask drops again.

Top module: `intvec_gen`

## Requirements
- R1: A synchronous active-low reset clears every register and pending flag. While reset is held and on the cycle after it, int_req and int_fast are 0 and int_vec_addr is 0. After reset all sources are at level 0, the base is 0 and neither fast slot is enabled.
- R2: A pending source is eligible only when its level is greater than or equal to sr_mask (mask 0 admits levels 0-3, mask 1 admits 1-3, mask 2 admits 2-3, mask 3 admits level 3 only). With no eligible source, int_req stays 0.
- R3: Among eligible sources, the one with the numerically highest level is presented.
- R4: Among eligible sources of equal highest level, the one with the lowest vector number is presented. Source i has vector number 16 + i.
- R5: For a normal interrupt, int_vec_addr equals {base[13:0], vector[6:0]}, which is 21 bits, and int_fast is 0.
- R6: If the winner's level is 2 and its vector equals an enabled slot's match vector, int_vec_addr equals that slot's {high[4:0], low[15:0]} and int_fast is 1.
- R7: A winner whose vector matches an enabled slot but whose level is not 2 is handled as in R5.
- R8: When both enabled slots match the winner, slot 0's address is used.
- R9: While int_req is 1 and int_ack is 0, int_req, int_vec_addr, int_vec_num and int_fast hold their values, even if new requests arrive or sr_mask changes.
- R10: The clock edge where int_req and int_ack are both 1 drops int_req and clears only the served source's pending flag. The next winner, if any, is presented one cycle later.
- R11: A slot whose enable bit (bit 7 of its match register) is 0 never matches, whatever its vector field holds.
- R12: A source that is pending but below the mask stays pending. It is presented once the mask is lowered to admit it.
- R13: Register map, written when wr_en is 1. Address 0 holds the levels, with source i at bits [2i+1:2i]. Address 1 holds the base in bits [13:0]. Addresses 2 and 3 are the match registers for slots 0 and 1, with the vector in bits [6:0] and the enable in bit 7. Addresses 4 and 5 hold slot 0's address low half [15:0] and high part [4:0]. Addresses 6 and 7 do the same for slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| irq_in | input | 8 | Request pulses, one per source |
| sr_mask | input | 2 | Core status mask level |
| int_ack | input | 1 | Core acknowledge of the presented request |
| int_req | output | 1 | Request to the core |
| int_vec_addr | output | 21 | Handler address |
| int_vec_num | output | 7 | Vector number of the presented source |
| int_fast | output | 1 | Presented request uses a fast slot |

## Verification
The hardest situation to reach from the ports is a request held while the world around it changes. This means a higher-level source arriving and the mask rising while an earlier, lower request is still waiting for its acknowledge. The bench reaches it by leaving the first request unacknowledged and pulsing a level-3 source. It then raises the mask to 3 and checks over several cycles that the presented address has not moved. Only after the acknowledge does it expect the level-3 vector. Slot precedence gets similar treatment: both slots are programmed with the same vector, the winner's level is toggled between 2 and 3, and slot 0 is then disabled so that slot 1 becomes visible.

// File: rtl/intvec_pkg.sv
// Package: shared types for the interrupt vector generator.
// Assumes two-bit priority levels and a 16-bit register data path.
package intvec_pkg;
    typedef logic [1:0] lvl_t;
    localparam int REG_DW = 16;
    localparam lvl_t FAST_LVL = 2'd2;
endpackage

// File: rtl/intvec_regs.sv
// Module: intvec_regs
// Holds the software-visible configuration: per-source levels, vector base,
// two fast-slot match registers and two fast-slot handler addresses.
// Assumes BASE_W <= 16 and ADDR_W - 16 <= 16; all state resets to zero.
module intvec_regs
    import intvec_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 7,
    parameter int BASE_W  = 14,
    parameter int ADDR_W  = 21,
    parameter int REG_AW  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [REG_AW-1:0]            wr_addr,
    input  logic [REG_DW-1:0]            wr_data,
    output logic [2*NUM_SRC-1:0]         src_lvl,
    output logic [BASE_W-1:0]            base_q,
    output logic [1:0][VEC_W-1:0]        slot_vec,
    output logic [1:0]                   slot_en,
    output logic [1:0][ADDR_W-1:0]       slot_addr
);
    localparam int PRI_REGS = (2*NUM_SRC + REG_DW - 1) / REG_DW;
    localparam int HI_W     = ADDR_W - REG_DW;
    localparam logic [REG_AW-1:0] A_BASE = REG_AW'(PRI_REGS);
    localparam logic [REG_AW-1:0] A_M0   = REG_AW'(PRI_REGS + 1);
    localparam logic [REG_AW-1:0] A_M1   = REG_AW'(PRI_REGS + 2);
    localparam logic [REG_AW-1:0] A_L0   = REG_AW'(PRI_REGS + 3);
    localparam logic [REG_AW-1:0] A_H0   = REG_AW'(PRI_REGS + 4);
    localparam logic [REG_AW-1:0] A_L1   = REG_AW'(PRI_REGS + 5);
    localparam logic [REG_AW-1:0] A_H1   = REG_AW'(PRI_REGS + 6);

    logic [PRI_REGS*REG_DW-1:0] pri_q;
    logic [1:0][VEC_W:0]        match_q;
    logic [1:0][REG_DW-1:0]     lo_q;
    logic [1:0][HI_W-1:0]       hi_q;

    // Purpose: decode the write port into the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_q   <= '0;
            base_q  <= '0;
            match_q <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else if (wr_en) begin
            for (int r = 0; r < PRI_REGS; r++) begin
                if (wr_addr == REG_AW'(r))
                    pri_q[r*REG_DW +: REG_DW] <= wr_data;
            end
            if (wr_addr == A_BASE) base_q     <= wr_data[BASE_W-1:0];
            if (wr_addr == A_M0)   match_q[0] <= wr_data[VEC_W:0];
            if (wr_addr == A_M1)   match_q[1] <= wr_data[VEC_W:0];
            if (wr_addr == A_L0)   lo_q[0]    <= wr_data;
            if (wr_addr == A_H0)   hi_q[0]    <= wr_data[HI_W-1:0];
            if (wr_addr == A_L1)   lo_q[1]    <= wr_data;
            if (wr_addr == A_H1)   hi_q[1]    <= wr_data[HI_W-1:0];
        end
    end

    assign src_lvl = pri_q[2*NUM_SRC-1:0];

    // Unpack each slot into its vector, enable and full address.
    for (genvar s = 0; s < 2; s++) begin : g_slot
        assign slot_vec[s]  = match_q[s][VEC_W-1:0];
        assign slot_en[s]   = match_q[s][VEC_W];
        assign slot_addr[s] = {hi_q[s], lo_q[s]};
    end
endmodule

// File: rtl/intvec_arb.sv
// Module: intvec_arb
// Keeps one pending flag per source and picks the eligible source with the
// highest level, ties going to the lowest index. Assumes a source is eligible
// when its level is at or above the mask; a new pulse wins over a clear.
module intvec_arb
    import intvec_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   irq_in,
    input  logic [2*NUM_SRC-1:0] src_lvl,
    input  lvl_t                 sr_mask,
    input  logic                 clr_en,
    input  logic [IDX_W-1:0]     clr_idx,
    output logic                 win_valid,
    output logic [IDX_W-1:0]     win_idx,
    output lvl_t                 win_lvl
);
    logic [NUM_SRC-1:0] pending_q;
    logic [NUM_SRC-1:0] clr_vec;

    // Purpose: one-hot clear vector for the acknowledged source.
    always_comb begin
        clr_vec = '0;
        if (clr_en) clr_vec = NUM_SRC'(1) << clr_idx;
    end

    // Purpose: capture request pulses and retire acknowledged sources.
    always_ff @(posedge clk) begin
        if (!rst_n) pending_q <= '0;
        else        pending_q <= (pending_q & ~clr_vec) | irq_in;
    end

    // Purpose: scan downward so equal levels leave the lowest index in place.
    always_comb begin
        lvl_t lv;
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            lv = src_lvl[2*i +: 2];
            if (pending_q[i] && (lv >= sr_mask) && (!win_valid || lv >= win_lvl)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_lvl   = lv;
            end
        end
    end
endmodule

// File: rtl/intvec_addr.sv
// Module: intvec_addr
// Forms the handler address for a winning vector: a fast slot address when
// the level is 2 and an enabled slot matches (slot 0 first), otherwise the
// base with the vector appended. Purely combinational.
module intvec_addr
    import intvec_pkg::*;
#(
    parameter int VEC_W  = 7,
    parameter int BASE_W = 14,
    parameter int ADDR_W = 21
) (
    input  logic [VEC_W-1:0]         vec_num,
    input  lvl_t                     lvl,
    input  logic [BASE_W-1:0]        base,
    input  logic [1:0][VEC_W-1:0]    slot_vec,
    input  logic [1:0]               slot_en,
    input  logic [1:0][ADDR_W-1:0]   slot_addr,
    output logic [ADDR_W-1:0]        addr,
    output logic                     fast
);
    logic [1:0] hit;

    // One comparator per fast slot.
    for (genvar s = 0; s < 2; s++) begin : g_hit
        assign hit[s] = slot_en[s] && (slot_vec[s] == vec_num) && (lvl == FAST_LVL);
    end

    // Purpose: choose between slot 0, slot 1 and the base-plus-vector address.
    always_comb begin
        fast = 1'b1;
        if (hit[0])      addr = slot_addr[0];
        else if (hit[1]) addr = slot_addr[1];
        else begin
            fast = 1'b0;
            addr = {base, vec_num};
        end
    end
endmodule

// File: rtl/intvec_gen.sv
// Module: intvec_gen (top)
// Prioritized interrupt vector generator. Latches the arbitration winner and
// its handler address, holds them until the core acknowledges, then retires
// the served source. Assumes source i carries vector VEC_OFS + i.
module intvec_gen
    import intvec_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 7,
    parameter int BASE_W  = 14,
    parameter int VEC_OFS = 16,
    parameter int REG_AW  = 4,
    localparam int ADDR_W = BASE_W + VEC_W,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_AW-1:0]  wr_addr,
    input  logic [15:0]        wr_data,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [1:0]         sr_mask,
    input  logic               int_ack,
    output logic               int_req,
    output logic [ADDR_W-1:0]  int_vec_addr,
    output logic [VEC_W-1:0]   int_vec_num,
    output logic               int_fast
);
    logic [2*NUM_SRC-1:0]     src_lvl;
    logic [BASE_W-1:0]        base_q;
    logic [1:0][VEC_W-1:0]    slot_vec;
    logic [1:0]               slot_en;
    logic [1:0][ADDR_W-1:0]   slot_addr;
    logic                     win_valid;
    logic [IDX_W-1:0]         win_idx;
    lvl_t                     win_lvl;
    logic [VEC_W-1:0]         win_vec;
    logic [ADDR_W-1:0]        win_addr;
    logic                     win_fast;

    logic                     req_q;
    logic [ADDR_W-1:0]        addr_q;
    logic [VEC_W-1:0]         vec_q;
    logic                     fast_q;
    logic [IDX_W-1:0]         idx_q;
    lvl_t                     lvl_q;

    intvec_regs #(
        .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .BASE_W(BASE_W),
        .ADDR_W(ADDR_W), .REG_AW(REG_AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .src_lvl(src_lvl), .base_q(base_q),
        .slot_vec(slot_vec), .slot_en(slot_en), .slot_addr(slot_addr)
    );

    intvec_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .src_lvl(src_lvl),
        .sr_mask(sr_mask), .clr_en(req_q && int_ack), .clr_idx(idx_q),
        .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    assign win_vec = VEC_W'(VEC_OFS) + VEC_W'(win_idx);

    intvec_addr #(.VEC_W(VEC_W), .BASE_W(BASE_W), .ADDR_W(ADDR_W)) u_addr (
        .vec_num(win_vec), .lvl(win_lvl), .base(base_q),
        .slot_vec(slot_vec), .slot_en(slot_en), .slot_addr(slot_addr),
        .addr(win_addr), .fast(win_fast)
    );

    // Purpose: present a winner and hold it unchanged until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            addr_q <= '0;
            vec_q  <= '0;
            fast_q <= 1'b0;
            idx_q  <= '0;
            lvl_q  <= '0;
        end else if (req_q) begin
            if (int_ack) req_q <= 1'b0;
        end else if (win_valid) begin
            req_q  <= 1'b1;
            addr_q <= win_addr;
            vec_q  <= win_vec;
            fast_q <= win_fast;
            idx_q  <= win_idx;
            lvl_q  <= win_lvl;
        end
    end

    assign int_req      = req_q;
    assign int_vec_addr = addr_q;
    assign int_vec_num  = vec_q;
    assign int_fast     = fast_q && req_q;
endmodule

// File: rtl/intvec_chk.sv
// Module: intvec_chk
// Protocol checker for intvec_gen, attached by bind. Watches the core-side
// handshake, the mask at the moment of presentation and the served level.
module intvec_chk #(
    parameter int ADDR_W = 21,
    parameter int VEC_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              int_req,
    input logic              int_ack,
    input logic              int_fast,
    input logic [ADDR_W-1:0] int_vec_addr,
    input logic [VEC_W-1:0]  int_vec_num,
    input logic [1:0]        sr_mask,
    input logic [1:0]        srv_lvl
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!int_req && !int_fast && int_vec_addr == '0));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && !int_ack) |=> (int_req && $stable(int_vec_addr)
                                   && $stable(int_vec_num) && $stable(int_fast)));

    // R10
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && int_ack) |=> !int_req);

    // R2
    mask_admit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_req) |-> (srv_lvl >= $past(sr_mask)));

    // R6
    fast_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_fast |-> (int_req && srv_lvl == 2'd2));
endmodule

bind intvec_gen intvec_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .int_req(int_req), .int_ack(int_ack),
    .int_fast(int_fast), .int_vec_addr(int_vec_addr),
    .int_vec_num(int_vec_num), .sr_mask(sr_mask), .srv_lvl(lvl_q)
);

// File: tb/intvec_gen_bench.sv
// Bench for intvec_gen: a table of arbitration vectors walked by one loop,
// then directed tests for fast slots, hold, acknowledge, masking and reset.
module intvec_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  irq_in = '0;
    logic [1:0]  sr_mask = '0;
    logic        int_ack = 1'b0;
    logic        int_req;
    logic [20:0] int_vec_addr;
    logic [6:0]  int_vec_num;
    logic        int_fast;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    intvec_gen u_intvec_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq_in(irq_in), .sr_mask(sr_mask),
        .int_ack(int_ack), .int_req(int_req), .int_vec_addr(int_vec_addr),
        .int_vec_num(int_vec_num), .int_fast(int_fast)
    );

    // Row layout: levels[16] base[14] mask[2] irq[8] exp_req[1] exp_vec[7]
    localparam logic [47:0] TBL [0:5] = '{
        {16'h0000, 14'h0001, 2'd0, 8'h01, 1'b1, 7'd16},  // R5 plain source 0
        {16'h00C0, 14'h0022, 2'd0, 8'h09, 1'b1, 7'd19},  // R3 level 3 beats level 0
        {16'h0808, 14'h0100, 2'd2, 8'h23, 1'b1, 7'd17},  // R4 tie at level 2, src1 over src5
        {16'h0000, 14'h0005, 2'd1, 8'hFF, 1'b0, 7'd0},   // R2 all level 0 under mask 1
        {16'h4000, 14'h0007, 2'd1, 8'h81, 1'b1, 7'd23},  // R2 src7 level 1 admitted by mask 1
        {16'hFFFF, 14'h3FFF, 2'd3, 8'h60, 1'b1, 7'd21}   // R2 mask 3 admits level 3, max base
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // Pulse, then one more edge so the winner is latched before sampling.
    task automatic pulse(input logic [7:0] p);
        @(negedge clk); irq_in = p;
        @(negedge clk); irq_in = '0;
        @(negedge clk);
    endtask

    task automatic ack();
        int_ack = 1'b1;
        @(negedge clk); int_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain();
        @(negedge clk); sr_mask = 2'd0;
        @(negedge clk);
        for (int n = 0; n < 12; n++) begin
            if (!int_req) break;
            ack();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] t_lvl; logic [13:0] t_base; logic [1:0] t_mask;
        logic [7:0] t_irq; logic t_req; logic [6:0] t_vec;

        repeat (3) @(negedge clk);
        chk("R1 req after reset", 32'(int_req), 32'd0);
        chk("R1 addr after reset", 32'(int_vec_addr), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 fast after reset", 32'(int_fast), 32'd0);

        for (int k = 0; k < 6; k++) begin
            {t_lvl, t_base, t_mask, t_irq, t_req, t_vec} = TBL[k];
            wr(4'd0, t_lvl);
            wr(4'd1, 16'(t_base));
            @(negedge clk); sr_mask = t_mask;
            pulse(t_irq);
            chk($sformatf("R2/R3/R4 row %0d req", k), 32'(int_req), 32'(t_req));
            if (t_req) begin
                chk($sformatf("R4 row %0d vec", k), 32'(int_vec_num), 32'(t_vec));
                chk($sformatf("R5 row %0d addr", k), 32'(int_vec_addr), 32'({t_base, t_vec}));
            end
            drain();
        end

        // R6, R13: slot 0 on source 2 (vector 18) at level 2
        wr(4'd0, 16'h0020); wr(4'd1, 16'h0100);
        wr(4'd2, 16'h0092); wr(4'd4, 16'hBEEF); wr(4'd5, 16'h0015);
        pulse(8'h04);
        chk("R6 fast flag", 32'(int_fast), 32'd1);
        chk("R6 fast addr", 32'(int_vec_addr), 32'h15BEEF);
        ack();

        // R7: same vector matched but level 3
        wr(4'd0, 16'h0030);
        pulse(8'h04);
        chk("R7 fast flag", 32'(int_fast), 32'd0);
        chk("R7 addr", 32'(int_vec_addr), 32'({14'h0100, 7'd18}));
        ack();

        // R8: both slots match, slot 0 wins
        wr(4'd0, 16'h0020); wr(4'd3, 16'h0092);
        wr(4'd6, 16'h1234); wr(4'd7, 16'h000A);
        pulse(8'h04);
        chk("R8 slot0 precedence", 32'(int_vec_addr), 32'h15BEEF);
        ack();

        // R11: slot 0 disabled, slot 1 takes over
        wr(4'd2, 16'h0012);
        pulse(8'h04);
        chk("R11 disabled slot skipped", 32'(int_vec_addr), 32'h0A1234);
        chk("R11 fast flag", 32'(int_fast), 32'd1);
        ack();

        // R9: hold while a higher source arrives and the mask rises
        wr(4'd3, 16'h0000); wr(4'd0, 16'h3020);
        pulse(8'h04);
        chk("R9 first vec", 32'(int_vec_num), 32'd18);
        @(negedge clk); irq_in = 8'h40; sr_mask = 2'd3;
        @(negedge clk); irq_in = '0;
        repeat (3) @(negedge clk);
        chk("R9 req held", 32'(int_req), 32'd1);
        chk("R9 addr held", 32'(int_vec_addr), 32'({14'h0100, 7'd18}));
        ack();
        chk("R9 next after ack", 32'(int_vec_num), 32'd22);
        ack();
        drain();

        // R10: ack retires only the served source
        wr(4'd0, 16'h0000);
        pulse(8'h0A);
        chk("R10 first", 32'(int_vec_num), 32'd17);
        ack();
        chk("R10 second still pending", 32'(int_vec_num), 32'd19);
        ack();
        chk("R10 none left", 32'(int_req), 32'd0);

        // R12: masked source waits, then is taken
        wr(4'd0, 16'h0100);
        @(negedge clk); sr_mask = 2'd2;
        pulse(8'h10);
        @(negedge clk);
        chk("R12 masked no req", 32'(int_req), 32'd0);
        sr_mask = 2'd0;
        @(negedge clk); @(negedge clk);
        chk("R12 taken after unmask", 32'(int_vec_num), 32'd20);
        ack();

        // R1: reset mid-request clears state and configuration
        wr(4'd0, 16'h0020); wr(4'd2, 16'h0092);
        pulse(8'h04);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 req cleared by reset", 32'(int_req), 32'd0);
        rst_n = 1'b1;
        pulse(8'h04);
        chk("R1 config cleared", 32'(int_vec_addr), 32'({14'h0000, 7'd18}));
        chk("R1 slots inactive", 32'(int_fast), 32'd0);
        ack();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule